// File: doc/BRIEF.md
# Rolling-Shutter Row Sequence Generator

This block sits on the camera side of a rolling-shutter image sensor. It produces, in master-clock cycles, the control pulses the sensor needs for each row. A row clock steps the row pointers, and a home strobe for each pointer sends it back to the first row. The other outputs are column precharge, row select, a signal-level hold, a reset-level hold and the pixel reset. Two pointer-drive enables choose which pointer owns the reset line. A one-cycle row-done strobe tells the column readout logic that the row has been sampled.

A frame starts on a start-of-frame pulse and runs for a programmed number of rows, then the block goes back to idle. Within each row a double-sampling sequence reads the row: precharge, select, hold the signal level, deselect, reset, hold the reset level. If the electronic shutter is enabled, a second pixel reset follows, with the reset line handed to the shutter pointer. That pointer leads the read pointer by a programmed number of rows, and this lead is the integration time. A dark-reference option adds a pixel reset during precharge so that the row reads black. Every pulse width and gap comes from its own input register, and a value of zero is taken as one cycle.

Top module: `rolling_row_sequencer`

## Requirements
- R1: After reset, and whenever no frame is running, every output is 0 except `drv_read`, which is 1. A `sof` seen while idle starts row 0 in the following cycle. A `sof` seen while a frame is running has no effect on the outputs.
- R2: Each row runs through these phases in order, and each phase lasts its register value in cycles, with a value of 0 counting as 1. The phases are: setup (`t_setup`, all pulses low); row clock high (`t_rowclk`); precharge (`t_prech`); gap (`t_prech_to_sel`); select only (`t_sel_to_sig`); select with `sig_hold` (`t_sig_hold`); select only (`t_sig_to_desel`); gap (`t_desel_to_rst`); `pix_rst` (`t_pix_rst`); gap (`t_rst_to_hold`); `rst_hold` (`t_rst_hold`). On both hold outputs, 1 means hold and 0 means track.
- R3: `prech` and `row_sel` are never 1 in the same cycle. `sig_hold` is 1 only while `row_sel` is 1. `pix_rst` is never 1 while `row_sel` is 1.
- R4: `row_clk` rises once per row. `read_home` is 1 during the setup and row-clock-high phases of row 0 only. It is therefore high for `t_setup` cycles before the rising edge of `row_clk` and through that edge.
- R5: `shut_home` is driven in the same phases as `read_home`, but only when the shutter is enabled. It is driven on row (rows − lead), or on row 0 when the lead is 0.
- R6: With the shutter enabled, three phases follow the reset-level hold: `drv_shut` alone for `t_shut_margin` cycles, then `drv_shut` with `pix_rst` for `t_shut_rst` cycles, then `drv_shut` alone for `t_shut_margin` cycles. `drv_read` is 0 exactly while `drv_shut` is 1. With the shutter disabled, all three phases are left out and `drv_shut` stays 0.
- R7: With dark reference enabled, `pix_rst` is 1 for the whole precharge phase of every row.
- R8: After the last hold phase of a row, `row_done` is 1 for exactly one cycle, followed by `t_blank` blanking cycles. After the blanking of the last row, the block returns to idle.
- R9: `rows_per_frame`, `lead_rows`, `shutter_en` and `black_en` are captured at the accepted `sof`. Changing them during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sof | input | 1 | Start-of-frame request |
| rows_per_frame | input | ROW_W | Rows per frame (0 counts as 1) |
| lead_rows | input | ROW_W | Shutter lead in rows |
| shutter_en | input | 1 | Enable the shutter second reset |
| black_en | input | 1 | Enable the dark-reference reset during precharge |
| t_setup | input | T_W | Home strobe setup before the row clock edge |
| t_rowclk | input | T_W | Row clock high time |
| t_prech | input | T_W | Precharge width |
| t_prech_to_sel | input | T_W | Gap from end of precharge to select |
| t_sel_to_sig | input | T_W | Select before the signal hold |
| t_sig_hold | input | T_W | Signal hold width |
| t_sig_to_desel | input | T_W | Select after the signal hold |
| t_desel_to_rst | input | T_W | Gap from deselect to pixel reset |
| t_pix_rst | input | T_W | Readout pixel reset width |
| t_rst_to_hold | input | T_W | Gap from reset to the reset hold |
| t_rst_hold | input | T_W | Reset-level hold width |
| t_shut_margin | input | T_W | Pointer drive margin on each side of the shutter reset |
| t_shut_rst | input | T_W | Shutter pixel reset width |
| t_blank | input | T_W | Blanking after row done |
| row_clk | output | 1 | Row pointer clock |
| read_home | output | 1 | Read pointer home strobe |
| shut_home | output | 1 | Shutter pointer home strobe |
| prech | output | 1 | Column precharge |
| row_sel | output | 1 | Row select |
| sig_hold | output | 1 | Signal-level hold (1 hold, 0 track) |
| rst_hold | output | 1 | Reset-level hold (1 hold, 0 track) |
| pix_rst | output | 1 | Pixel reset |
| drv_read | output | 1 | Read pointer drives the reset line |
| drv_shut | output | 1 | Shutter pointer drives the reset line |
| row_done | output | 1 | One-cycle row sampled strobe |

## Verification
The assertions assume only two things about the inputs: `lead_rows` is smaller than `rows_per_frame`, and the timing registers stay steady while a frame runs. Zero-valued widths are stretched to one cycle, so every overlap and setup property holds for any width value. The stimulus changes timing registers only between frames and always keeps the lead below the row count. The capture-at-start rule is exercised by changing the frame-shape inputs and pulsing `sof` in the middle of a frame.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

   typedef enum logic [4:0] {
      PH_IDLE, PH_SETUP, PH_ROWCLK, PH_PRECH, PH_GAP_PS, PH_SEL_PRE,
      PH_SIG_HOLD, PH_SEL_POST, PH_GAP_SR, PH_PIX_RST, PH_GAP_RH,
      PH_RST_HOLD, PH_SH_LEAD, PH_SH_RST, PH_SH_TRAIL, PH_DONE, PH_BLANK
   } phase_e;

   typedef struct packed {
      logic row_clk;
      logic read_home;
      logic shut_home;
      logic prech;
      logic row_sel;
      logic sig_hold;
      logic rst_hold;
      logic pix_rst;
      logic drv_read;
      logic drv_shut;
      logic done;
   } pins_t;

   localparam int unsigned MCLK_KHZ = 15000;

   function automatic int unsigned ns2cyc(int unsigned ns);
      return (ns * MCLK_KHZ + 999999) / 1000000;
   endfunction

   localparam int unsigned DEF_SETUP       = ns2cyc(200);
   localparam int unsigned DEF_ROWCLK      = ns2cyc(500);
   localparam int unsigned DEF_PRECH       = ns2cyc(2700);
   localparam int unsigned DEF_PRECH_SEL   = ns2cyc(1300);
   localparam int unsigned DEF_SEL_SIG     = ns2cyc(1000);
   localparam int unsigned DEF_SIG_HOLD    = ns2cyc(1400);
   localparam int unsigned DEF_SIG_DESEL   = ns2cyc(500);
   localparam int unsigned DEF_DESEL_RST   = ns2cyc(100);
   localparam int unsigned DEF_PIX_RST     = ns2cyc(1300);
   localparam int unsigned DEF_RST_HOLD_GAP = ns2cyc(500);
   localparam int unsigned DEF_RST_HOLD    = ns2cyc(1400);
   localparam int unsigned DEF_SHUT_MARGIN = ns2cyc(100);
   localparam int unsigned DEF_SHUT_RST    = ns2cyc(1300);
   localparam int unsigned DEF_BLANK       = ns2cyc(5000);

   function automatic phase_e phase_after(phase_e p, logic shut, logic last);
      case (p)
         PH_SETUP:    return PH_ROWCLK;
         PH_ROWCLK:   return PH_PRECH;
         PH_PRECH:    return PH_GAP_PS;
         PH_GAP_PS:   return PH_SEL_PRE;
         PH_SEL_PRE:  return PH_SIG_HOLD;
         PH_SIG_HOLD: return PH_SEL_POST;
         PH_SEL_POST: return PH_GAP_SR;
         PH_GAP_SR:   return PH_PIX_RST;
         PH_PIX_RST:  return PH_GAP_RH;
         PH_GAP_RH:   return PH_RST_HOLD;
         PH_RST_HOLD: return shut ? PH_SH_LEAD : PH_DONE;
         PH_SH_LEAD:  return PH_SH_RST;
         PH_SH_RST:   return PH_SH_TRAIL;
         PH_SH_TRAIL: return PH_DONE;
         PH_DONE:     return PH_BLANK;
         PH_BLANK:    return last ? PH_IDLE : PH_SETUP;
         default:     return PH_IDLE;
      endcase
   endfunction

endpackage

// File: rtl/rsq_phase_timer.sv
module rsq_phase_timer #(
   parameter int T_W = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic [T_W-1:0] load_val,
   output logic           expired
);
   logic [T_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= (load_val == '0) ? '0 : load_val - 1'b1;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);
endmodule

// File: rtl/rsq_frame_track.sv
module rsq_frame_track #(
   parameter int ROW_W     = 13,
   parameter int NEXT_VIEW = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             adv,
   input  logic [ROW_W-1:0] rows_in,
   input  logic [ROW_W-1:0] lead_in,
   input  logic             shut_in,
   input  logic             black_in,
   output logic             last_c,
   output logic             shut_c,
   output logic             first_v,
   output logic             shrow_v,
   output logic             black_v
);
   logic [ROW_W-1:0] row_q, rows_q, lead_q;
   logic             shut_q, black_q;
   logic [ROW_W-1:0] row_n, rows_n, lead_n;
   logic             shut_n, black_n;

   function automatic logic [2:0] row_flags(logic [ROW_W-1:0] row,
                                            logic [ROW_W-1:0] rows,
                                            logic [ROW_W-1:0] lead,
                                            logic shut);
      logic [ROW_W-1:0] rows_e, srow;
      rows_e = (rows == '0) ? {{(ROW_W-1){1'b0}}, 1'b1} : rows;
      srow   = (lead == '0) ? '0 : rows_e - lead;
      return {row == '0, shut && (row == srow), row == rows_e - 1'b1};
   endfunction

   always_comb begin
      row_n   = row_q;
      rows_n  = rows_q;
      lead_n  = lead_q;
      shut_n  = shut_q;
      black_n = black_q;
      if (start) begin
         row_n   = '0;
         rows_n  = rows_in;
         lead_n  = lead_in;
         shut_n  = shut_in;
         black_n = black_in;
      end else if (adv) begin
         row_n = row_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_q   <= '0;
         rows_q  <= '0;
         lead_q  <= '0;
         shut_q  <= 1'b0;
         black_q <= 1'b0;
      end else begin
         row_q   <= row_n;
         rows_q  <= rows_n;
         lead_q  <= lead_n;
         shut_q  <= shut_n;
         black_q <= black_n;
      end
   end

   logic [2:0] fl_c;
   assign fl_c   = row_flags(row_q, rows_q, lead_q, shut_q);
   assign last_c = fl_c[0];
   assign shut_c = shut_q;

   generate
      if (NEXT_VIEW != 0) begin : g_next
         logic [2:0] fl_n;
         assign fl_n    = row_flags(row_n, rows_n, lead_n, shut_n);
         assign first_v = fl_n[2];
         assign shrow_v = fl_n[1];
         assign black_v = black_n;
      end else begin : g_cur
         assign first_v = fl_c[2];
         assign shrow_v = fl_c[1];
         assign black_v = black_q;
      end
   endgenerate
endmodule

// File: rtl/rsq_pin_decode.sv
module rsq_pin_decode
   import rsq_pkg::*;
(
   input  phase_e ph,
   input  logic   first_row,
   input  logic   shut_row,
   input  logic   black,
   output pins_t  pins
);
   always_comb begin
      pins          = '0;
      pins.drv_read = 1'b1;
      case (ph)
         PH_SETUP: begin
            pins.read_home = first_row;
            pins.shut_home = shut_row;
         end
         PH_ROWCLK: begin
            pins.row_clk   = 1'b1;
            pins.read_home = first_row;
            pins.shut_home = shut_row;
         end
         PH_PRECH: begin
            pins.prech   = 1'b1;
            pins.pix_rst = black;
         end
         PH_SEL_PRE, PH_SEL_POST: pins.row_sel = 1'b1;
         PH_SIG_HOLD: begin
            pins.row_sel  = 1'b1;
            pins.sig_hold = 1'b1;
         end
         PH_PIX_RST:  pins.pix_rst  = 1'b1;
         PH_RST_HOLD: pins.rst_hold = 1'b1;
         PH_SH_LEAD, PH_SH_TRAIL: begin
            pins.drv_shut = 1'b1;
            pins.drv_read = 1'b0;
         end
         PH_SH_RST: begin
            pins.drv_shut = 1'b1;
            pins.drv_read = 1'b0;
            pins.pix_rst  = 1'b1;
         end
         PH_DONE: pins.done = 1'b1;
         default: ;
      endcase
   end
endmodule

// File: rtl/rolling_row_sequencer.sv
module rolling_row_sequencer
   import rsq_pkg::*;
#(
   parameter int T_W     = 8,
   parameter int ROW_W   = 13,
   parameter int REG_OUT = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sof,
   input  logic [ROW_W-1:0] rows_per_frame,
   input  logic [ROW_W-1:0] lead_rows,
   input  logic             shutter_en,
   input  logic             black_en,
   input  logic [T_W-1:0]   t_setup,
   input  logic [T_W-1:0]   t_rowclk,
   input  logic [T_W-1:0]   t_prech,
   input  logic [T_W-1:0]   t_prech_to_sel,
   input  logic [T_W-1:0]   t_sel_to_sig,
   input  logic [T_W-1:0]   t_sig_hold,
   input  logic [T_W-1:0]   t_sig_to_desel,
   input  logic [T_W-1:0]   t_desel_to_rst,
   input  logic [T_W-1:0]   t_pix_rst,
   input  logic [T_W-1:0]   t_rst_to_hold,
   input  logic [T_W-1:0]   t_rst_hold,
   input  logic [T_W-1:0]   t_shut_margin,
   input  logic [T_W-1:0]   t_shut_rst,
   input  logic [T_W-1:0]   t_blank,
   output logic             row_clk,
   output logic             read_home,
   output logic             shut_home,
   output logic             prech,
   output logic             row_sel,
   output logic             sig_hold,
   output logic             rst_hold,
   output logic             pix_rst,
   output logic             drv_read,
   output logic             drv_shut,
   output logic             row_done
);
   localparam logic [T_W-1:0] ONE_CYC = {{(T_W-1){1'b0}}, 1'b1};

   if (T_W < 2) begin : g_bad_tw
      $error("rolling_row_sequencer: T_W must be at least 2");
   end
   if (ROW_W < 1) begin : g_bad_row
      $error("rolling_row_sequencer: ROW_W must be at least 1");
   end
   if (REG_OUT != 0 && REG_OUT != 1) begin : g_bad_reg
      $error("rolling_row_sequencer: REG_OUT must be 0 or 1");
   end

   phase_e          ph, ph_n;
   logic            load, expired, start, adv;
   logic [T_W-1:0]  load_val;
   logic            last_c, shut_c, first_v, shrow_v, black_v;
   pins_t           pins_d, pins_o;

   always_comb begin
      ph_n = ph;
      load = 1'b0;
      if (ph == PH_IDLE) begin
         if (sof) begin
            ph_n = PH_SETUP;
            load = 1'b1;
         end
      end else if (expired) begin
         ph_n = phase_after(ph, shut_c, last_c);
         load = (ph_n != PH_IDLE);
      end
   end

   assign start = (ph == PH_IDLE) && sof;
   assign adv   = (ph == PH_BLANK) && expired;

   always_comb begin
      case (ph_n)
         PH_SETUP:    load_val = t_setup;
         PH_ROWCLK:   load_val = t_rowclk;
         PH_PRECH:    load_val = t_prech;
         PH_GAP_PS:   load_val = t_prech_to_sel;
         PH_SEL_PRE:  load_val = t_sel_to_sig;
         PH_SIG_HOLD: load_val = t_sig_hold;
         PH_SEL_POST: load_val = t_sig_to_desel;
         PH_GAP_SR:   load_val = t_desel_to_rst;
         PH_PIX_RST:  load_val = t_pix_rst;
         PH_GAP_RH:   load_val = t_rst_to_hold;
         PH_RST_HOLD: load_val = t_rst_hold;
         PH_SH_LEAD:  load_val = t_shut_margin;
         PH_SH_RST:   load_val = t_shut_rst;
         PH_SH_TRAIL: load_val = t_shut_margin;
         PH_BLANK:    load_val = t_blank;
         default:     load_val = ONE_CYC;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph <= PH_IDLE;
      else        ph <= ph_n;
   end

   rsq_phase_timer #(.T_W(T_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_val (load_val),
      .expired  (expired)
   );

   rsq_frame_track #(.ROW_W(ROW_W), .NEXT_VIEW(REG_OUT)) u_frame (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .adv      (adv),
      .rows_in  (rows_per_frame),
      .lead_in  (lead_rows),
      .shut_in  (shutter_en),
      .black_in (black_en),
      .last_c   (last_c),
      .shut_c   (shut_c),
      .first_v  (first_v),
      .shrow_v  (shrow_v),
      .black_v  (black_v)
   );

   generate
      if (REG_OUT != 0) begin : g_reg_out
         pins_t pins_q;
         rsq_pin_decode u_dec (
            .ph        (ph_n),
            .first_row (first_v),
            .shut_row  (shrow_v),
            .black     (black_v),
            .pins      (pins_d)
         );
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pins_q          <= '0;
               pins_q.drv_read <= 1'b1;
            end else begin
               pins_q <= pins_d;
            end
         end
         assign pins_o = pins_q;
      end else begin : g_comb_out
         rsq_pin_decode u_dec (
            .ph        (ph),
            .first_row (first_v),
            .shut_row  (shrow_v),
            .black     (black_v),
            .pins      (pins_d)
         );
         assign pins_o = pins_d;
      end
   endgenerate

   assign row_clk   = pins_o.row_clk;
   assign read_home = pins_o.read_home;
   assign shut_home = pins_o.shut_home;
   assign prech     = pins_o.prech;
   assign row_sel   = pins_o.row_sel;
   assign sig_hold  = pins_o.sig_hold;
   assign rst_hold  = pins_o.rst_hold;
   assign pix_rst   = pins_o.pix_rst;
   assign drv_read  = pins_o.drv_read;
   assign drv_shut  = pins_o.drv_shut;
   assign row_done  = pins_o.done;
endmodule

// File: rtl/rsq_checker.sv
module rsq_checker (
   input logic clk,
   input logic rst_n,
   input logic row_clk,
   input logic read_home,
   input logic shut_home,
   input logic prech,
   input logic row_sel,
   input logic sig_hold,
   input logic rst_hold,
   input logic pix_rst,
   input logic drv_shut,
   input logic row_done
);
   p_prech_sel_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(prech && row_sel));
   p_sig_hold_in_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
      sig_hold |-> row_sel);
   p_rst_not_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
      pix_rst |-> !row_sel);

   p_read_home_setup_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(row_clk) && read_home) |-> $past(read_home));
   p_read_home_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(read_home) |-> !row_clk);
   p_read_home_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(read_home) |-> $past(row_clk));

   p_shut_home_setup_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(row_clk) && shut_home) |-> $past(shut_home));
   p_shut_home_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(shut_home) |-> !row_clk);

   p_shut_lead_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(pix_rst) && drv_shut) |-> $past(drv_shut));
   p_shut_trail_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(pix_rst) && $past(drv_shut)) |-> drv_shut);
   p_shut_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      drv_shut |-> (!prech && !row_sel && !sig_hold && !rst_hold));

   p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      row_done |=> !row_done);
   p_done_after_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rst_hold) |-> (row_done || drv_shut));
endmodule

bind rolling_row_sequencer rsq_checker u_rsq_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .row_clk   (row_clk),
   .read_home (read_home),
   .shut_home (shut_home),
   .prech     (prech),
   .row_sel   (row_sel),
   .sig_hold  (sig_hold),
   .rst_hold  (rst_hold),
   .pix_rst   (pix_rst),
   .drv_shut  (drv_shut),
   .row_done  (row_done)
);

// File: tb/rolling_row_sequencer_test.sv
`timescale 1ns/1ps
module rolling_row_sequencer_test;
   import rsq_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int T_W   = 8;
   localparam int ROW_W = 13;
   localparam logic [10:0] IDLE_V = 11'b000_0000_0100;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sof = 1'b0;
   logic [ROW_W-1:0] rows_per_frame = '0, lead_rows = '0;
   logic shutter_en = 1'b0, black_en = 1'b0;
   logic [T_W-1:0] tv [14];

   wire [10:0] act_r, act_c;
   wire r_rc, r_rh, r_sh, r_pc, r_se, r_sg, r_rs, r_px, r_dr, r_ds, r_dn;
   wire c_rc, c_rh, c_sh, c_pc, c_se, c_sg, c_rs, c_px, c_dr, c_ds, c_dn;

   rolling_row_sequencer #(.T_W(T_W), .ROW_W(ROW_W), .REG_OUT(1)) uut (
      .clk(clk), .rst_n(rst_n), .sof(sof), .rows_per_frame(rows_per_frame),
      .lead_rows(lead_rows), .shutter_en(shutter_en), .black_en(black_en),
      .t_setup(tv[0]), .t_rowclk(tv[1]), .t_prech(tv[2]), .t_prech_to_sel(tv[3]),
      .t_sel_to_sig(tv[4]), .t_sig_hold(tv[5]), .t_sig_to_desel(tv[6]),
      .t_desel_to_rst(tv[7]), .t_pix_rst(tv[8]), .t_rst_to_hold(tv[9]),
      .t_rst_hold(tv[10]), .t_shut_margin(tv[11]), .t_shut_rst(tv[12]),
      .t_blank(tv[13]),
      .row_clk(r_rc), .read_home(r_rh), .shut_home(r_sh), .prech(r_pc),
      .row_sel(r_se), .sig_hold(r_sg), .rst_hold(r_rs), .pix_rst(r_px),
      .drv_read(r_dr), .drv_shut(r_ds), .row_done(r_dn));

   rolling_row_sequencer #(.T_W(T_W), .ROW_W(ROW_W), .REG_OUT(0)) uut_comb (
      .clk(clk), .rst_n(rst_n), .sof(sof), .rows_per_frame(rows_per_frame),
      .lead_rows(lead_rows), .shutter_en(shutter_en), .black_en(black_en),
      .t_setup(tv[0]), .t_rowclk(tv[1]), .t_prech(tv[2]), .t_prech_to_sel(tv[3]),
      .t_sel_to_sig(tv[4]), .t_sig_hold(tv[5]), .t_sig_to_desel(tv[6]),
      .t_desel_to_rst(tv[7]), .t_pix_rst(tv[8]), .t_rst_to_hold(tv[9]),
      .t_rst_hold(tv[10]), .t_shut_margin(tv[11]), .t_shut_rst(tv[12]),
      .t_blank(tv[13]),
      .row_clk(c_rc), .read_home(c_rh), .shut_home(c_sh), .prech(c_pc),
      .row_sel(c_se), .sig_hold(c_sg), .rst_hold(c_rs), .pix_rst(c_px),
      .drv_read(c_dr), .drv_shut(c_ds), .row_done(c_dn));

   assign act_r = {r_rc, r_rh, r_sh, r_pc, r_se, r_sg, r_rs, r_px, r_dr, r_ds, r_dn};
   assign act_c = {c_rc, c_rh, c_sh, c_pc, c_se, c_sg, c_rs, c_px, c_dr, c_ds, c_dn};

   logic [10:0] exp_q [$];
   int n_cmp = 0, n_bad = 0, cyc = 0;
   bit checking = 1'b0;
   string cur_req = "R1";

   always #(CLK_PERIOD/2) clk = ~clk;

   // bits: row_clk read_home shut_home prech row_sel sig_hold rst_hold pix_rst drv_read drv_shut done
   function automatic logic [10:0] mk(bit rc, bit rh, bit sh, bit pc, bit se,
                                      bit sg, bit rs, bit px, bit ds, bit dn);
      return {rc, rh, sh, pc, se, sg, rs, px, !ds, ds, dn};
   endfunction

   function automatic int eff(logic [T_W-1:0] t);
      return (t == 0) ? 1 : int'(t);
   endfunction

   task automatic push(int n, logic [10:0] v);
      for (int i = 0; i < n; i++) exp_q.push_back(v);
   endtask

   task automatic build_frame();
      int rows_e, srow;
      rows_e = (rows_per_frame == 0) ? 1 : int'(rows_per_frame);
      srow   = (lead_rows == 0) ? 0 : rows_e - int'(lead_rows);
      for (int k = 0; k < rows_e; k++) begin
         bit rh, sh;
         rh = (k == 0);
         sh = shutter_en && (k == srow);
         push(eff(tv[0]),  mk(0, rh, sh, 0, 0, 0, 0, 0, 0, 0));
         push(eff(tv[1]),  mk(1, rh, sh, 0, 0, 0, 0, 0, 0, 0));
         push(eff(tv[2]),  mk(0, 0, 0, 1, 0, 0, 0, black_en, 0, 0));
         push(eff(tv[3]),  IDLE_V);
         push(eff(tv[4]),  mk(0, 0, 0, 0, 1, 0, 0, 0, 0, 0));
         push(eff(tv[5]),  mk(0, 0, 0, 0, 1, 1, 0, 0, 0, 0));
         push(eff(tv[6]),  mk(0, 0, 0, 0, 1, 0, 0, 0, 0, 0));
         push(eff(tv[7]),  IDLE_V);
         push(eff(tv[8]),  mk(0, 0, 0, 0, 0, 0, 0, 1, 0, 0));
         push(eff(tv[9]),  IDLE_V);
         push(eff(tv[10]), mk(0, 0, 0, 0, 0, 0, 1, 0, 0, 0));
         if (shutter_en) begin
            push(eff(tv[11]), mk(0, 0, 0, 0, 0, 0, 0, 0, 1, 0));
            push(eff(tv[12]), mk(0, 0, 0, 0, 0, 0, 0, 1, 1, 0));
            push(eff(tv[11]), mk(0, 0, 0, 0, 0, 0, 0, 0, 1, 0));
         end
         push(1, mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 1));
         push(eff(tv[13]), IDLE_V);
      end
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   always @(negedge clk) begin
      if (checking) begin
         logic [10:0] e;
         e = (exp_q.size() != 0) ? exp_q.pop_front() : IDLE_V;
         n_cmp += 2;
         if (act_r !== e) begin
            n_bad++;
            $display("FAIL %s registered outputs cycle %0d actual %b expected %b",
                     cur_req, cyc, act_r, e);
         end
         if (act_c !== e) begin
            n_bad++;
            $display("FAIL %s combinational outputs cycle %0d actual %b expected %b",
                     cur_req, cyc, act_c, e);
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_bad++;
         n_cmp++;
         $display("FAIL watchdog expired at cycle %0d actual running expected idle", cyc);
         finish_run();
      end
   end

   task automatic start_frame();
      wait (exp_q.size() == 0);
      @(negedge clk); #1;
      build_frame();
      sof = 1'b1;
      @(negedge clk); #1;
      sof = 1'b0;
   endtask

   task automatic wait_idle();
      wait (exp_q.size() == 0);
      repeat (3) @(negedge clk);
   endtask

   task automatic set_small();
      int vals [14] = '{3, 2, 4, 1, 2, 3, 2, 1, 3, 2, 3, 1, 2, 4};
      for (int i = 0; i < 14; i++) tv[i] = T_W'(vals[i]);
   endtask

   task automatic set_defaults();
      tv[0] = T_W'(DEF_SETUP);        tv[1] = T_W'(DEF_ROWCLK);
      tv[2] = T_W'(DEF_PRECH);        tv[3] = T_W'(DEF_PRECH_SEL);
      tv[4] = T_W'(DEF_SEL_SIG);      tv[5] = T_W'(DEF_SIG_HOLD);
      tv[6] = T_W'(DEF_SIG_DESEL);    tv[7] = T_W'(DEF_DESEL_RST);
      tv[8] = T_W'(DEF_PIX_RST);      tv[9] = T_W'(DEF_RST_HOLD_GAP);
      tv[10] = T_W'(DEF_RST_HOLD);    tv[11] = T_W'(DEF_SHUT_MARGIN);
      tv[12] = T_W'(DEF_SHUT_RST);    tv[13] = T_W'(DEF_BLANK);
   endtask

   initial begin
      set_small();
      repeat (2) @(posedge clk);
      checking = 1'b1;
      cur_req = "R1 reset state";
      repeat (3) @(negedge clk);
      #1 rst_n = 1'b1;
      repeat (4) @(negedge clk);

      cur_req = "R2/R3/R4/R8 full-frame sequence";
      rows_per_frame = 3; lead_rows = 1; shutter_en = 0; black_en = 0;
      start_frame(); wait_idle();

      cur_req = "R5/R6 shutter lead 1 of 4 rows";
      rows_per_frame = 4; lead_rows = 1; shutter_en = 1;
      start_frame(); wait_idle();

      cur_req = "R5/R6 shutter lead 3 of 5 rows";
      rows_per_frame = 5; lead_rows = 3;
      start_frame(); wait_idle();

      cur_req = "R5 shutter lead 0";
      rows_per_frame = 2; lead_rows = 0;
      start_frame(); wait_idle();

      cur_req = "R7 dark reference";
      rows_per_frame = 2; lead_rows = 1; shutter_en = 0; black_en = 1;
      start_frame(); wait_idle();

      cur_req = "R7/R6 dark reference with shutter";
      shutter_en = 1;
      start_frame(); wait_idle();

      cur_req = "R2 zero widths count as one";
      for (int i = 0; i < 14; i++) tv[i] = '0;
      rows_per_frame = 3; lead_rows = 2; shutter_en = 1; black_en = 0;
      start_frame(); wait_idle();

      cur_req = "R2 zero row count";
      set_small();
      rows_per_frame = 0; lead_rows = 0; shutter_en = 0;
      start_frame(); wait_idle();

      cur_req = "R9/R1 mid-frame changes and extra start ignored";
      rows_per_frame = 3; lead_rows = 1; shutter_en = 0; black_en = 0;
      start_frame();
      repeat (15) @(negedge clk); #1;
      shutter_en = 1; black_en = 1; rows_per_frame = 6; lead_rows = 2; sof = 1'b1;
      @(negedge clk); #1 sof = 1'b0;
      repeat (30) @(negedge clk); #1 sof = 1'b1;
      @(negedge clk); #1 sof = 1'b0;
      wait_idle();

      cur_req = "R2/R6/R8 recommended default timing";
      set_defaults();
      rows_per_frame = 2; lead_rows = 1; shutter_en = 1; black_en = 0;
      start_frame(); wait_idle();

      cur_req = "R1 idle after frames";
      repeat (5) @(negedge clk);
      finish_run();
   end
endmodule